// File: doc/BRIEF.md
# Debug Control and Breakpoint Unit

This block holds the 8-bit control register of an on-chip debugger, together with the small amount of logic that acts on it. A debug host writes the register to halt or restart the processor, to arm breakpoint handling, to turn on an acknowledge byte, and to request a device reset. The processor reports each decoded breakpoint instruction as a one-cycle strobe. An option input marks the device as read-protected.

If breakpoints are disarmed, a breakpoint strobe does nothing, exactly like a no-op. If they are armed, the strobe forces debug mode, which raises the halt output so that instruction fetch stops. When the acknowledge option is also on and the processor was running, the block raises a one-cycle request to send the code 0xFF to the host. Under read protection, writes cannot leave debug mode; only a power-on reset does. The reset-request bit drives the device reset output until the reset sequencer reports completion, and then the bit clears itself. This debug unit is reset only by its own power-on reset input and never by the device reset it requests.

Top module: `dbg_ctrl_unit`

## Requirements
- R1: After power-on reset, the register reads 0x00, and halt, ack_req and dev_rst are all 0.
- R2: Bit 7 is the debug-mode flag. A write takes effect on the next clock edge: a 1 sets the flag and a 0 clears it (when no protection is active). halt always equals this flag.
- R3: While bit 6 (breakpoint enable) is 0, a breakpoint strobe changes nothing, and ack_req stays 0.
- R4: While bit 6 is 1, a breakpoint strobe sets the debug-mode flag on the next clock edge.
- R5: Suppose a breakpoint strobe arrives while bit 6 and bit 5 are both 1 and the flag is 0. Then ack_req is 1 for exactly one cycle, starting on the same edge that sets the flag, and ack_byte is 0xFF. No ack_req is raised if bit 5 is 0 or if the flag is already 1.
- R6: While rd_protect is 1, a write cannot clear a set debug-mode flag. Writing a 1 to the flag is still allowed.
- R7: Writing a 1 to bit 0 sets that bit and raises dev_rst on the next edge. A write of 0 does not cancel a pending request. The bit clears on the edge after rst_done is seen. rst_done has no effect while no request is pending. Bits 7, 6 and 5 keep their values throughout.
- R8: Bits 4 to 1 always read as 0, whatever value is written to them.
- R9: A breakpoint strobe (with bit 6 set) and a write of 0 to bit 7 in the same cycle leave the flag set.
- R10: Bits 6 and 5 read back the value last written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe from the debug host |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| brk_strobe | input | 1 | Breakpoint instruction decoded, one cycle |
| rd_protect | input | 1 | Read-protect option is active |
| rst_done | input | 1 | Reset sequencer has completed the device reset |
| halt | output | 1 | Stop fetching instructions |
| ack_req | output | 1 | Send the acknowledge byte to the host, one cycle |
| ack_byte | output | 8 | Acknowledge code (0xFF) |
| dev_rst | output | 1 | Device reset request |

## Verification
Some rules are checked by assertions on every cycle. These are: an armed breakpoint always sets the flag, a disarmed one leaves it unchanged, the lock under protection holds, ack_req stays a single pulse tied to the flag, and dev_rst is held until completion and then dropped. Other behaviour shows up only in the bench's scenarios. That covers the exact read-back values, the reserved bits reading zero, the conditions that suppress the acknowledge, the priority of a breakpoint over a simultaneous clearing write, and the fact that a write of 0 cannot cancel a pending device reset.

// File: rtl/dbg_ctrl_pkg.sv
package dbg_ctrl_pkg;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned POS_MODE  = 7;
  localparam int unsigned POS_BRKEN = 6;
  localparam int unsigned POS_ACKEN = 5;
  localparam int unsigned POS_RST   = 0;
  localparam int unsigned SYNC_LEN  = 2;
endpackage

// File: rtl/dbg_cfg_reg.sv
// Breakpoint arm and acknowledge enable bits.
module dbg_cfg_reg (
  input  logic clk,
  input  logic rst_ni,
  input  logic wr_en,
  input  logic wr_brk_en,
  input  logic wr_ack_en,
  output logic brk_en,
  output logic ack_en
);
  logic brk_en_q, brk_en_d;
  logic ack_en_q, ack_en_d;

  always_comb begin
    brk_en_d = brk_en_q;
    ack_en_d = ack_en_q;
    if (wr_en) begin
      brk_en_d = wr_brk_en;
      ack_en_d = wr_ack_en;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_en_q <= 1'b0;
      ack_en_q <= 1'b0;
    end else begin
      brk_en_q <= brk_en_d;
      ack_en_q <= ack_en_d;
    end
  end

  assign brk_en = brk_en_q;
  assign ack_en = ack_en_q;

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> ($stable(brk_en_q) && $stable(ack_en_q)));
endmodule

// File: rtl/dbg_mode_ctrl.sv
// Debug-mode flag, breakpoint handling and acknowledge pulse.
module dbg_mode_ctrl (
  input  logic clk,
  input  logic rst_ni,
  input  logic wr_en,
  input  logic wr_mode,
  input  logic brk_strobe,
  input  logic brk_en,
  input  logic ack_en,
  input  logic rd_protect,
  output logic mode,
  output logic ack_pulse
);
  logic mode_q, mode_d;
  logic ack_q, ack_d;
  logic brk_taken;

  assign brk_taken = brk_strobe & brk_en;

  always_comb begin
    mode_d = mode_q;
    if (brk_taken)
      mode_d = 1'b1;
    else if (wr_en)
      mode_d = wr_mode | (rd_protect & mode_q);
    ack_d = brk_taken & ack_en & ~mode_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 1'b0;
      ack_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      ack_q  <= ack_d;
    end
  end

  assign mode      = mode_q;
  assign ack_pulse = ack_q;

  p_brk_sets_mode_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (brk_strobe && brk_en) |=> mode_q);
  p_brk_off_nop_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (brk_strobe && !brk_en && !wr_en) |=> ($stable(mode_q) && !ack_q));
  p_protect_lock_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_protect && mode_q) |=> mode_q);
  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  p_ack_with_mode_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    ack_q |-> mode_q);
endmodule

// File: rtl/dbg_rst_ctrl.sv
// Self-clearing device reset request.
module dbg_rst_ctrl (
  input  logic clk,
  input  logic rst_ni,
  input  logic wr_en,
  input  logic wr_rst,
  input  logic rst_done,
  output logic rst_pend
);
  logic pend_q, pend_d;

  always_comb begin
    if (pend_q)
      pend_d = ~rst_done;
    else
      pend_d = wr_en & wr_rst;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign rst_pend = pend_q;

  p_rst_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !rst_done) |=> pend_q);
  p_rst_clear_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && rst_done) |=> !pend_q);
  p_rst_start_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (!pend_q && !(wr_en && wr_rst)) |=> !pend_q);
endmodule

// File: rtl/dbg_ctrl_unit.sv
module dbg_ctrl_unit #(
  parameter int unsigned REG_W    = dbg_ctrl_pkg::CTRL_W,
  parameter logic [REG_W-1:0] ACK_CODE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             brk_strobe,
  input  logic             rd_protect,
  input  logic             rst_done,
  output logic             halt,
  output logic             ack_req,
  output logic [REG_W-1:0] ack_byte,
  output logic             dev_rst
);
  import dbg_ctrl_pkg::*;

  localparam int unsigned SL = SYNC_LEN;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [SL-1:0] rst_sync_q;
  logic          rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SL-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SL-1];

  logic brk_en, ack_en, mode, ack_pulse, rst_pend;

  dbg_cfg_reg u_cfg (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .wr_en     (wr_en),
    .wr_brk_en (wr_data[POS_BRKEN]),
    .wr_ack_en (wr_data[POS_ACKEN]),
    .brk_en    (brk_en),
    .ack_en    (ack_en)
  );

  dbg_mode_ctrl u_mode (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .wr_en      (wr_en),
    .wr_mode    (wr_data[POS_MODE]),
    .brk_strobe (brk_strobe),
    .brk_en     (brk_en),
    .ack_en     (ack_en),
    .rd_protect (rd_protect),
    .mode       (mode),
    .ack_pulse  (ack_pulse)
  );

  dbg_rst_ctrl u_rst (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .wr_en    (wr_en),
    .wr_rst   (wr_data[POS_RST]),
    .rst_done (rst_done),
    .rst_pend (rst_pend)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[POS_MODE]  = mode;
    rd_data[POS_BRKEN] = brk_en;
    rd_data[POS_ACKEN] = ack_en;
    rd_data[POS_RST]   = rst_pend;
  end

  assign halt     = mode;
  assign ack_req  = ack_pulse;
  assign ack_byte = ACK_CODE;
  assign dev_rst  = rst_pend;

  p_halt_mirror_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    halt == rd_data[POS_MODE]);
endmodule

// File: tb/tb_dbg_ctrl_unit.sv
module tb_dbg_ctrl_unit;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       brk_strobe, rd_protect, rst_done;
  logic       halt, ack_req, dev_rst;
  logic [7:0] ack_byte;

  always #2 clk = ~clk;

  dbg_ctrl_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .brk_strobe(brk_strobe), .rd_protect(rd_protect),
    .rst_done(rst_done), .halt(halt), .ack_req(ack_req),
    .ack_byte(ack_byte), .dev_rst(dev_rst)
  );

  typedef struct {
    logic [7:0] rd;
    logic       ack;
    int         req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic check(input bit ok, input int req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus; the expected state after the next edge is queued.
  task automatic step(input bit we, input logic [7:0] wd, input bit brk,
                      input bit prot, input bit rdone,
                      input logic [7:0] exp_rd, input bit exp_ack, input int req);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; brk_strobe = brk; rd_protect = prot; rst_done = rdone;
    e.rd = exp_rd; e.ack = exp_ack; e.req = req;
    exp_q.push_back(e);
  endtask

  // Monitor: compares one queued item per clock, 1 ns after the edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(rd_data == e.rd, e.req, "rd_data", rd_data, e.rd);
      check(halt == e.rd[7], e.req, "halt", {7'b0, halt}, {7'b0, e.rd[7]});
      check(dev_rst == e.rd[0], e.req, "dev_rst", {7'b0, dev_rst}, {7'b0, e.rd[0]});
      check(ack_req == e.ack, e.req, "ack_req", {7'b0, ack_req}, {7'b0, e.ack});
      if (e.ack) check(ack_byte == 8'hFF, e.req, "ack_byte", ack_byte, 8'hFF);
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; wr_data = '0; brk_strobe = 0; rd_protect = 0; rst_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(rd_data == 8'h00, 1, "reset rd_data", rd_data, 8'h00);
    check({halt, ack_req, dev_rst} == 3'b000, 1, "reset outputs",
          {5'b0, halt, ack_req, dev_rst}, 8'h00);

    step(0, 8'h00, 0, 0, 0, 8'h00, 0, 1);  // R1 idle
    step(0, 8'h00, 1, 0, 0, 8'h00, 0, 3);  // R3 disarmed breakpoint is a no-op
    step(1, 8'h60, 0, 0, 0, 8'h60, 0, 10); // R10 arm + ack enable
    step(1, 8'h7E, 0, 0, 0, 8'h60, 0, 8);  // R8 reserved bits read 0
    step(1, 8'h80, 0, 0, 0, 8'h80, 0, 2);  // R2 set flag, R10 bits 6/5 cleared
    step(1, 8'hE0, 0, 0, 0, 8'hE0, 0, 2);  // R2 write keeps flag, no ack on write
    step(1, 8'h60, 0, 0, 0, 8'h60, 0, 2);  // R2 clear flag
    step(0, 8'h00, 1, 0, 0, 8'hE0, 1, 5);  // R4 + R5 breakpoint taken with ack
    step(0, 8'h00, 1, 0, 0, 8'hE0, 0, 5);  // R5 no second ack while in debug mode
    step(1, 8'h40, 0, 0, 0, 8'h40, 0, 10); // R10 ack disabled
    step(0, 8'h00, 1, 0, 0, 8'hC0, 0, 5);  // R5 no ack when bit 5 is 0; R4 flag set
    step(1, 8'h40, 0, 0, 0, 8'h40, 0, 2);
    step(1, 8'h40, 1, 0, 0, 8'hC0, 0, 9);  // R9 breakpoint beats clearing write
    step(1, 8'h40, 0, 1, 0, 8'hC0, 0, 6);  // R6 protected flag not cleared
    step(0, 8'h00, 0, 1, 0, 8'hC0, 0, 6);  // R6 still held
    step(1, 8'h40, 0, 0, 0, 8'h40, 0, 2);  // R2 clear once unprotected
    step(1, 8'hC0, 0, 1, 0, 8'hC0, 0, 6);  // R6 set allowed under protection
    step(1, 8'h00, 0, 1, 0, 8'h80, 0, 6);  // R6 flag locked, bit 6 cleared
    step(1, 8'h40, 0, 0, 0, 8'h40, 0, 2);
    step(0, 8'h00, 0, 0, 1, 8'h40, 0, 7);  // R7 rst_done ignored when idle
    step(1, 8'h41, 0, 0, 0, 8'h41, 0, 7);  // R7 reset request starts
    step(1, 8'h40, 0, 0, 0, 8'h41, 0, 7);  // R7 write 0 does not cancel
    step(0, 8'h00, 0, 0, 0, 8'h41, 0, 7);  // R7 held until done
    step(0, 8'h00, 0, 0, 1, 8'h40, 0, 7);  // R7 self-clear, bit 6 kept
    step(0, 8'h00, 0, 0, 0, 8'h40, 0, 7);
    step(1, 8'h00, 0, 0, 0, 8'h00, 0, 10);
    step(0, 8'h00, 1, 0, 0, 8'h00, 0, 3);  // R3 disarmed again
    step(0, 8'h00, 0, 0, 0, 8'h00, 0, 3);

    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule